// File: doc/BRIEF.md
# Fourth-Order Cascaded Biquad Low-Pass Filter

This block is a fixed-point recursive (IIR) filter. It builds a fourth-order response from two second-order sections in series. On each clock where the enable is high it accepts one signed integer sample. It returns a wide signed result in 24.14 fixed point, meaning 24 integer bits and 14 fraction bits. Each section runs the difference equation y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. All products are kept at full precision. The sum is then shifted right by the coefficient fraction width, and only the low bits of the section's word width are kept.

Each section has its own coefficient set, fixed at elaboration. The coefficients are 10-bit signed numbers with 8 fraction bits. Splitting the recursion into two sections keeps each feedback loop short and lets each section be scaled on its own.

The output of the first section goes into the second section in the same cycle, at full width. The second section's result register is the block output, so there is one enabled clock of latency from a sample to its first effect on the output.

Top module: `iir4_cascade`

## Requirements
- R1: A synchronous, active-high reset sets the output and every history register in both sections to zero. After reset, enabled cycles with zero input keep the output at zero.
- R2: While the clock enable is low, the output and all history registers hold their values. Stalled cycles are invisible to the response: it resumes as if they never occurred.
- R3: A sample taken on an enabled edge changes the output on that same edge, with one enabled clock of latency. With all history at zero, the first output equals the sample scaled by b0 of section one and then by b0 of section two.
- R4: The impulse response, meaning one nonzero sample followed by zeros, matches the two-section difference equation exactly, bit for bit.
- R5: The step response, meaning a constant input held for many samples, matches the difference equation exactly. It settles near the DC gain of the cascade.
- R6: The input is a 13-bit two's-complement integer in the range −4096 to 4095. It is sign-extended and shifted left by 14 to enter section one as a 24.14 value. Negative inputs and both extremes are handled exactly.
- R7: In each section the five products are formed at full precision. The sum is shifted right arithmetically by 8, then truncated to the section width of 38 bits, wrapping in two's complement. The next feedback value is registered in its own adder register.
- R8: Section one's output feeds section two in the same cycle and is sign-extended with no truncation. There is no register between the sections.
- R9: The output is 38 bits, signed, with 14 fraction bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clken | input | 1 | Sample enable; when low, all state holds |
| x_in | input | 13 | Signed integer input sample |
| y_out | output | 38 | Filtered result, signed 24.14 |

## Verification
The hardest case to reach from the ports is the clock enable dropping in the middle of a decaying response. The state then holds both a feed-forward history and a registered feedback sum that must be frozen together. A skew between the two only appears several samples later.

The stimulus reaches this case by first driving an impulse and a step. It then applies long random stretches in which both the enable and the sample are random. The bench compares every cycle against a bit-accurate model that advances only on enabled, non-reset cycles. Extreme negative and positive inputs and a reset in mid-response complete the directed cases.

// File: rtl/iir4_pkg.sv
package iir4_pkg;

  // Coefficient word: signed, IIR_CF fraction bits.
  localparam int unsigned IIR_CW = 10;
  localparam int unsigned IIR_CF = 8;

  // Default sample and result geometry.
  localparam int unsigned IIR_XW = 13;
  localparam int unsigned IIR_SW = 38;
  localparam int unsigned IIR_QF = 14;

  // Extra accumulator headroom for a sum of up to five products.
  localparam int unsigned IIR_GUARD = 3;

  typedef logic signed [IIR_CW-1:0] coef_t;

  typedef struct packed {
    coef_t b0;
    coef_t b1;
    coef_t b2;
    coef_t a1;
    coef_t a2;
  } biquad_coef_t;

endpackage

// File: rtl/iir4_mac.sv
module iir4_mac
  import iir4_pkg::*;
#(
  parameter int unsigned NT  = 3,
  parameter int unsigned DW  = IIR_SW,
  parameter int unsigned AW  = IIR_SW + IIR_CW + IIR_GUARD,
  parameter bit          NEG = 1'b0,
  parameter coef_t       CO [NT] = '{default: '0}
) (
  input  logic signed [DW-1:0] d   [NT],
  output logic signed [AW-1:0] sum
);

  logic signed [AW-1:0] prod [NT];

  for (genvar i = 0; i < NT; i++) begin : g_tap
    assign prod[i] = AW'(d[i]) * AW'(CO[i]);
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NT; i++) begin
      if (NEG) sum = sum - prod[i];
      else     sum = sum + prod[i];
    end
  end

endmodule

// File: rtl/iir4_biquad.sv
module iir4_biquad
  import iir4_pkg::*;
#(
  parameter int unsigned  DW = IIR_SW,
  parameter int unsigned  CF = IIR_CF,
  parameter biquad_coef_t C  = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x_in,
  output logic signed [DW-1:0] y_now,
  output logic signed [DW-1:0] y_reg
);

  localparam int unsigned AW = DW + IIR_CW + IIR_GUARD;
  localparam coef_t FF_CO [3] = '{C.b0, C.b1, C.b2};
  localparam coef_t FB_CO [2] = '{C.a1, C.a2};

  logic signed [DW-1:0] x_d1, x_d2, y_d1;
  logic signed [AW-1:0] fb_q;
  logic signed [AW-1:0] ff_sum, fb_sum, acc;
  logic signed [DW-1:0] ff_in [3];
  logic signed [DW-1:0] fb_in [2];

  assign ff_in[0] = x_in;
  assign ff_in[1] = x_d1;
  assign ff_in[2] = x_d2;

  iir4_mac #(.NT(3), .DW(DW), .AW(AW), .NEG(1'b0), .CO(FF_CO)) u_ff (
    .d   (ff_in),
    .sum (ff_sum)
  );

  // Feedback for the next sample, from the fresh output and the last one.
  assign fb_in[0] = y_now;
  assign fb_in[1] = y_d1;

  iir4_mac #(.NT(2), .DW(DW), .AW(AW), .NEG(1'b1), .CO(FB_CO)) u_fb (
    .d   (fb_in),
    .sum (fb_sum)
  );

  assign acc   = ff_sum + fb_q;
  assign y_now = DW'(acc >>> CF);
  assign y_reg = y_d1;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_d1 <= '0;
      x_d2 <= '0;
      y_d1 <= '0;
      fb_q <= '0;
    end else if (en) begin
      x_d1 <= x_in;
      x_d2 <= x_d1;
      y_d1 <= y_now;
      fb_q <= fb_sum;
    end
  end

endmodule

// File: rtl/iir4_cascade.sv
module iir4_cascade
  import iir4_pkg::*;
#(
  parameter int unsigned  XW   = IIR_XW,
  parameter int unsigned  S1W  = IIR_SW,
  parameter int unsigned  SW   = IIR_SW,
  parameter int unsigned  QF   = IIR_QF,
  parameter int unsigned  CF   = IIR_CF,
  parameter biquad_coef_t SEC1 = '{b0: 10'sd16, b1: 10'sd32, b2: 10'sd16,
                                   a1: -10'sd359, a2: 10'sd164},
  parameter biquad_coef_t SEC2 = '{b0: 10'sd10, b1: 10'sd20, b2: 10'sd10,
                                   a1: -10'sd342, a2: 10'sd125}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clken,
  input  logic signed [XW-1:0] x_in,
  output logic signed [SW-1:0] y_out
);

  logic signed [S1W-1:0] s1_in, s1_now, s1_reg;
  logic signed [SW-1:0]  s2_in, s2_now, s2_reg;

  assign s1_in = S1W'(x_in) <<< QF;

  iir4_biquad #(.DW(S1W), .CF(CF), .C(SEC1)) u_sec1 (
    .clk   (clk),
    .rst   (rst),
    .en    (clken),
    .x_in  (s1_in),
    .y_now (s1_now),
    .y_reg (s1_reg)
  );

  // Full-width hand-off: sign-extend into the second section's word.
  if (SW > S1W) begin : g_widen
    assign s2_in = SW'(s1_now);
  end else begin : g_same
    assign s2_in = s1_now;
  end

  iir4_biquad #(.DW(SW), .CF(CF), .C(SEC2)) u_sec2 (
    .clk   (clk),
    .rst   (rst),
    .en    (clken),
    .x_in  (s2_in),
    .y_now (s2_now),
    .y_reg (s2_reg)
  );

  assign y_out = s2_reg;

endmodule

// File: rtl/iir4_cascade_chk.sv
module iir4_cascade_chk
  import iir4_pkg::*;
#(
  parameter int unsigned  XW   = IIR_XW,
  parameter int unsigned  SW   = IIR_SW,
  parameter int unsigned  QF   = IIR_QF,
  parameter int unsigned  CF   = IIR_CF,
  parameter biquad_coef_t SEC1 = '0,
  parameter biquad_coef_t SEC2 = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic signed [XW-1:0] x,
  input logic signed [SW-1:0] y
);

  localparam int unsigned AW = SW + IIR_CW + IIR_GUARD;

  logic                 quiet;
  logic signed [SW-1:0] xq, h1, h2, head_q;

  assign xq = SW'(x) <<< QF;
  assign h1 = SW'((AW'(xq) * AW'(SEC1.b0)) >>> CF);
  assign h2 = SW'((AW'(h1) * AW'(SEC2.b0)) >>> CF);

  always_ff @(posedge clk) begin
    if (rst)                 quiet <= 1'b1;
    else if (en && x != '0)  quiet <= 1'b0;
    if (en) head_q <= h2;
  end

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> y == '0);

  p_quiet_zero_r1: assert property (@(posedge clk) disable iff (rst)
    quiet |-> y == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y));

  p_first_out_r3: assert property (@(posedge clk) disable iff (rst)
    (quiet && en) |=> y == head_q);

endmodule

bind iir4_cascade iir4_cascade_chk #(
  .XW(XW), .SW(SW), .QF(QF), .CF(CF), .SEC1(SEC1), .SEC2(SEC2)
) u_chk (
  .clk (clk),
  .rst (rst),
  .en  (clken),
  .x   (x_in),
  .y   (y_out)
);

// File: tb/iir4_cascade_tb.sv
`timescale 1ns/1ps
module iir4_cascade_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               clken = 1'b0;
  logic signed [12:0] x_in = '0;
  logic signed [37:0] y_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iir4_cascade u_dut (
    .clk   (clk),
    .rst   (rst),
    .clken (clken),
    .x_in  (x_in),
    .y_out (y_out)
  );

  // Coefficients written out from the requirements: b0 b1 b2 a1 a2.
  longint cf [2][5] = '{'{16, 32, 16, -359, 164}, '{10, 20, 10, -342, 125}};
  longint mx1 [2], mx2 [2], my1 [2], my2 [2];
  longint mout;

  function automatic longint wrap38(input longint v);
    longint t;
    t = v <<< 26;
    return t >>> 26;
  endfunction

  task automatic m_reset();
    for (int s = 0; s < 2; s++) begin
      mx1[s] = 0; mx2[s] = 0; my1[s] = 0; my2[s] = 0;
    end
    mout = 0;
  endtask

  task automatic m_step(input longint xs);
    longint u, acc, yv;
    u = xs * 16384;
    for (int s = 0; s < 2; s++) begin
      acc = cf[s][0]*u + cf[s][1]*mx1[s] + cf[s][2]*mx2[s]
          - cf[s][3]*my1[s] - cf[s][4]*my2[s];
      yv = wrap38(acc >>> 8);
      mx2[s] = mx1[s]; mx1[s] = u;
      my2[s] = my1[s]; my1[s] = yv;
      u = yv;
    end
    mout = u;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (longint'(y_out) != mout) begin
      n_bad++;
      $display("FAIL %s: y_out=%0d expected=%0d", tag, y_out, mout);
    end
  endtask

  task automatic tick(input int xv, input bit ev, input bit rv, input string tag);
    @(negedge clk);
    x_in  = 13'(xv);
    clken = ev;
    rst   = rv;
    @(posedge clk);
    #1;
    if (rv)      m_reset();
    else if (ev) m_step(longint'(x_in));
    check(tag);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    m_reset();

    // R1: reset state, then zero input keeps zero
    for (int i = 0; i < 3; i++) tick(0, 1, 1, "R1 reset");
    for (int i = 0; i < 5; i++) tick(0, 1, 0, "R1 zero input");

    // R3/R8: first output appears on the sampling edge; R4 impulse tail
    tick(1000, 1, 0, "R3 first output");
    for (int i = 0; i < 60; i++) tick(0, 1, 0, "R4 impulse");

    // R5: step response, R9 format settles near gain * 16384 * level
    tick(0, 1, 1, "R1 reset");
    for (int i = 0; i < 120; i++) tick(1, 1, 0, "R5 step");
    for (int i = 0; i < 80; i++) tick(2000, 1, 0, "R9 step level");

    // R6: input extremes
    tick(0, 1, 1, "R1 reset");
    tick(-4096, 1, 0, "R6 min first");
    for (int i = 0; i < 60; i++) tick(-4096, 1, 0, "R6 min step");
    for (int i = 0; i < 60; i++) tick(4095, 1, 0, "R6 max step");
    for (int i = 0; i < 30; i++) tick((i % 2) ? 4095 : -4096, 1, 0, "R6 alternate");

    // R2: stall in mid-response
    for (int i = 0; i < 12; i++) tick(777, 0, 0, "R2 stall");
    for (int i = 0; i < 20; i++) tick(0, 1, 0, "R2 resume");

    // R7: random samples, random enable
    for (int i = 0; i < 400; i++) begin
      int xv;
      bit ev;
      xv = int'($urandom_range(8191)) - 4096;
      ev = ($urandom_range(3) != 0);
      tick(xv, ev, 0, ev ? "R7 random" : "R2 random stall");
    end

    // R1: reset in mid-response, then quiet
    tick(0, 1, 1, "R1 mid reset");
    for (int i = 0; i < 5; i++) tick(0, 1, 0, "R1 after reset");
    tick(-1, 1, 0, "R3 small negative");
    for (int i = 0; i < 20; i++) tick(0, 1, 0, "R4 small impulse");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule